// File: doc/BRIEF.md
# Self-Recovering Zero-Coded Ring Sequencer

This block steps through NUM_STATES states in a fixed ring using only NUM_STATES−1 flip-flops. The first state is coded as the all-zero vector. Each other state has a single bit set, and that bit moves one stage toward bit 0 on every advance. The first stage, which is the most significant bit, is fed by the NOR of all state bits. Because of this, the ring leaves the all-zero state by inserting a single 1, and it returns to all-zero after the 1 drops off the end of the chain.

The same feedback lets the ring recover from transient upsets without a reset. If a 1 is lost, the register becomes the all-zero vector, which is itself a legal state, and the sequence restarts from the first state. If extra 1s appear, nothing new is inserted while any bit is set. Every 1 then shifts out of the last stage within NUM_STATES−1 advances, and the ring is back on its legal cycle. A flag shows when more than one bit is set. A binary index output reports the current state.

Top module: `modhot_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every state bit, so after that edge state_o is 0, index_o is 0 and multi_o is 0.
- R2: While advance is low at a clock edge (and rst is low), state_o keeps its value.
- R3: When advance is high and state_o is all zero, the edge loads a 1 into the top bit (bit NUM_STATES−2) only.
- R4: When advance is high and state_o is non-zero, every bit moves one position toward bit 0, bit 0 is discarded, and the top bit becomes 0. After NUM_STATES advances from all zero, the register is all zero again.
- R5: While multi_o is 0, index_o is 0 for the all-zero vector and NUM_STATES−1−k when only bit k is set. Each advance therefore raises the index by one, and it wraps from NUM_STATES−1 to 0.
- R6: multi_o is 1 exactly when two or more bits of state_o are set. index_o carries no meaning in that case.
- R7: From any contents, after NUM_STATES−1 advances with no reset, at most one bit is set, and the ring then follows the legal sequence.
- R8: If an upset clears the register in the middle of the sequence, the outputs show state 0 and the next advance loads the top bit, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step the ring by one state at this edge |
| state_o | output | NUM_STATES−1 | Raw state register, bit NUM_STATES−2 is the first stage |
| index_o | output | clog2(NUM_STATES) | Binary number of the current state |
| multi_o | output | 1 | More than one state bit is set |

## Verification
The bench goes after the wrap from the last single-bit state back to all zero. A design with the feedback wired wrongly would stall in the last state or insert a 1 too early and carry two bits. It forces the register to contents that carry an extra 1, and to all ones, and counts advances until the ring is legal again. A design that fed the first stage from the last stage, with no NOR, would circulate the extra bits forever. It also clears the register in the middle of the sequence, where a design without the NOR insertion would lock at zero. Finally, it checks that the index is wrong in no single-bit state, which catches an off-by-one or reversed bit order.

// File: rtl/modhot_seq.sv
module modhot_seq #(
  parameter int NUM_STATES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          advance,
  output logic [NUM_STATES-2:0]         state_o,
  output logic [$clog2(NUM_STATES)-1:0] index_o,
  output logic                          multi_o
);
  localparam int W  = NUM_STATES - 1;
  localparam int IW = $clog2(NUM_STATES);

  logic [W-1:0] state_q;
  logic         feed;

  assign feed = ~|state_q;

  always_ff @(posedge clk) begin
    if (rst)          state_q <= '0;
    else if (advance) state_q <= {feed, state_q[W-1:1]};
  end

  assign state_o = state_q;
  assign multi_o = |(state_q & (state_q - W'(1)));

  always_comb begin
    index_o = '0;
    for (int k = 0; k < W; k++)
      if (state_q[k]) index_o = IW'(W - k);
  end
endmodule

module modhot_seq_chk #(
  parameter int NUM_STATES = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          advance,
  input logic [NUM_STATES-2:0]         state,
  input logic [$clog2(NUM_STATES)-1:0] index,
  input logic                          multi
);
  localparam int W  = NUM_STATES - 1;
  localparam int IW = $clog2(NUM_STATES);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  // A change seen between the falling and rising edge is a disturbance, not a transition.
  logic [W-1:0] seen;
  logic         seen_valid = 1'b0;
  logic         upset;

  always_ff @(negedge clk) begin
    seen       <= state;
    seen_valid <= 1'b1;
  end
  assign upset = seen_valid && (state != seen);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (upset)
    rst |=> (state == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst || upset)
    !advance |=> $stable(state));

  assert_insert_top_R3: assert property (@(posedge clk) disable iff (rst || upset)
    (advance && state == '0) |=> (state == TOP));

  assert_shift_down_R4: assert property (@(posedge clk) disable iff (rst || upset)
    (advance && state != '0) |=> (state == ($past(state) >> 1)));

  assert_index_step_R5: assert property (@(posedge clk) disable iff (rst || upset)
    (advance && !multi && index != IW'(W)) |=> (multi || index == $past(index) + IW'(1)));

  assert_index_wrap_R5: assert property (@(posedge clk) disable iff (rst || upset)
    (advance && !multi && index == IW'(W)) |=> (index == '0 && state == '0));

  assert_multi_flag_R6: assert property (@(posedge clk) disable iff (rst)
    multi == ($countones(state) > 1));
endmodule

bind modhot_seq modhot_seq_chk #(.NUM_STATES(NUM_STATES)) chk_i (
  .clk(clk), .rst(rst), .advance(advance),
  .state(state_q), .index(index_o), .multi(multi_o)
);

// File: tb/modhot_seq_tb_top.sv
module modhot_seq_tb_top;
  localparam int NUM_STATES = 8;
  localparam int W  = NUM_STATES - 1;
  localparam int IW = $clog2(NUM_STATES);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0;
  logic [W-1:0]  state_o;
  logic [IW-1:0] index_o;
  logic          multi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] model = '0;

  modhot_seq #(.NUM_STATES(NUM_STATES)) dut_i (
    .clk(clk), .rst(rst), .advance(advance),
    .state_o(state_o), .index_o(index_o), .multi_o(multi_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] next_of(logic [W-1:0] v);
    if (v == '0) return {1'b1, {(W-1){1'b0}}};
    return v >> 1;
  endfunction

  function automatic int index_of(logic [W-1:0] v);
    for (int k = 0; k < W; k++)
      if (v[k]) return W - k;
    return 0;
  endfunction

  task automatic check_val(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    bit exp_multi;
    exp_multi = ($countones(model) > 1);
    check_val(req, "state", int'(state_o), int'(model));
    check_val("R6", "multi", int'(multi_o), int'(exp_multi));
    if (!exp_multi) check_val("R5", "index", int'(index_o), index_of(model));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic tick(logic a, string req);
    advance = a;
    @(posedge clk);
    if (rst) model = '0;
    else if (a) model = next_of(model);
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic inject(logic [W-1:0] v, string req);
    #(CLK_PERIOD/4);
    force dut_i.state_q = v;
    #1;
    release dut_i.state_q;
    model = v;
    #1;
    check_outputs(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5e_ed07));
    @(negedge clk);
    rst = 1'b1;
    tick(1'b0, "R1");
    tick(1'b1, "R1");
    rst = 1'b0;

    // R2: hold at zero
    tick(1'b0, "R2");
    tick(1'b0, "R2");

    // R3 insertion, R4 shifting over a full ring, then wrap
    tick(1'b1, "R3");
    for (int i = 1; i < NUM_STATES; i++) tick(1'b1, "R4");
    check_val("R4", "wrap to zero", int'(state_o), 0);

    // R2 hold mid-sequence
    for (int i = 0; i < 3; i++) tick(1'b1, "R4");
    tick(1'b0, "R2");
    tick(1'b0, "R2");

    // R8: cleared register restarts
    inject('0, "R8");
    check_val("R8", "index after clear", int'(index_o), 0);
    tick(1'b1, "R8");
    check_val("R8", "top bit after clear", int'(state_o[W-1]), 1);

    // R7: extra 1 is flushed
    tick(1'b1, "R4");
    inject(model | W'(1), "R6");
    check_val("R6", "multi with extra bit", int'(multi_o), 1);
    for (int i = 0; i < W; i++) tick(1'b1, "R7");
    check_val("R7", "bits set after flush", $countones(state_o), (state_o == '0) ? 0 : 1);
    checks++;
    if ($countones(state_o) > 1) begin
      fails++;
      $display("FAIL R7 ones actual=%0d expected<=1", $countones(state_o));
    end

    // R7: all ones drains to zero
    inject('1, "R6");
    for (int i = 0; i < W; i++) tick(1'b1, "R7");
    check_val("R7", "all ones drained", int'(state_o), 0);
    for (int i = 0; i < NUM_STATES; i++) tick(1'b1, "R4");

    // R1: reset while multi-hot
    inject(W'(5), "R6");
    rst = 1'b1;
    tick(1'b1, "R1");
    rst = 1'b0;

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 199));
      rst = (r < 2);
      if (r >= 2 && r < 8 && !rst) inject(W'($urandom), "R7");
      tick(logic'($urandom_range(0, 1)), "R4");
    end
    rst = 1'b0;
    for (int i = 0; i < W; i++) tick(1'b1, "R7");
    checks++;
    if ($countones(state_o) > 1) begin
      fails++;
      $display("FAIL R7 ones actual=%0d expected<=1", $countones(state_o));
    end
    finish_run();
  end
endmodule